// File: doc/BRIEF.md
# Bit-Configurable GPIO Port Controller

This block is the register side of an 8-bit general purpose I/O port. Software reaches it through a small register window: a data register, a configuration register, a pin-level read address and, as a companion, an output-only drive port. For each bit, the configuration bit and the data bit together set the pad mode. The block produces output-enable, output-value and pull-up-enable for each pad. Pad levels pass through a synchronizer before software can read them.

When the `SPECIAL` parameter is set, the port becomes the control port variant. Its two top data bits are not stored. Writing a 1 to one of them sends a one-cycle request to the power-mode logic: bit 7 requests halt and bit 6 requests idle. The two top configuration bits become static controls: bit 6 selects the alternate serial clock phase and bit 7 enables the start-up delay after halt. Pins 6 and 7 are held as plain inputs. A watchdog option input takes over pin 1, which then acts as an open-drain watchdog output with a pull-up.

Top module: `gpio_port_ctrl`

## Requirements
- R1: For a bidirectional pin, the pair {configuration bit, data bit} selects the mode. 00 gives Hi-Z input (oe=0, pu=0). 01 gives input with pull-up (oe=0, pu=1). 10 drives 0 (oe=1, out=0, pu=0). 11 drives 1 (oe=1, out=1, pu=0).
- R2: While reset is low, and after it is released, the configuration and data registers read as zero and every pad has oe=0 and pu=0.
- R3: The output-only drive port reads and drives all ones (0xFF) while reset is low. Afterwards it takes the value written at address 3.
- R4: The address map is: 0 = data, 1 = configuration, 2 = pin levels, 3 = drive port. A write with `wr_en` high for one cycle updates only the register that `addr` selects, at that clock edge.
- R5: Address 2 returns the pad levels two clock edges after they are applied, whatever the configuration. A write to address 2 changes no register.
- R6: In the special variant, a write to address 0 with data bit 7 set raises `halt_req` for exactly the one cycle after the write edge. Data bit 6 does the same for `idle_req`. A write with these bits clear raises nothing.
- R7: In the special variant, configuration bit 6 drives `alt_sk_phase` and configuration bit 7 drives `clkdly_en`. Pads 6 and 7 stay at oe=0 and pu=0.
- R8: In the special variant, reading address 0 always returns 0 in bits 6 and 7.
- R9: In the special variant, while `wdog_opt` is 1, pad 1 has pu=1 and out=0, and oe equals the inverse of `wdog_level`. The configuration and data bits for pin 1 have no effect on pad 1 in this state.
- R10: Reading addresses 0 and 1 returns the last value written there, with bits 6 and 7 of address 0 masked as R8 states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected address |
| pad_in | input | 8 | Raw pad input levels |
| pad_oe | output | 8 | Per-pad output enable |
| pad_out | output | 8 | Per-pad output value |
| pad_pu | output | 8 | Per-pad pull-up enable |
| drv_port | output | 8 | Output-only port value |
| wdog_opt | input | 1 | Watchdog takes pin 1 |
| wdog_level | input | 1 | Watchdog output level |
| halt_req | output | 1 | One-cycle halt request |
| idle_req | output | 1 | One-cycle idle request |
| alt_sk_phase | output | 1 | Alternate serial clock phase select |
| clkdly_en | output | 1 | Start-up delay after halt enable |

## Verification
Pad outputs are a direct decode of register state. A wrong configuration or data bit therefore shows on `pad_oe`, `pad_out` or `pad_pu` in the cycle right after the write edge, and on readback at the same moment. Request pulses are checked cycle by cycle, so a pulse that sticks or repeats shows up one cycle later. A synchronizer with the wrong depth makes address 2 disagree within two edges of a pad change. Random writes across all four addresses also show any stray update to a register that was not selected.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

   typedef enum logic [1:0] {
      REG_DATA = 2'd0,
      REG_CFG  = 2'd1,
      REG_PIN  = 2'd2,
      REG_DRV  = 2'd3
   } gpio_reg_e;

   typedef struct packed {
      logic oe;
      logic out;
      logic pu;
   } pin_drive_t;

   // {cfg,data}: 00 hi-z, 01 pull-up input, 10 drive low, 11 drive high
   function automatic pin_drive_t decode_mode(input logic cfg_b, input logic dat_b);
      pin_drive_t r;
      r.oe  = cfg_b;
      r.out = cfg_b & dat_b;
      r.pu  = ~cfg_b & dat_b;
      return r;
   endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stg [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      stg[s] <= '0;
            else if (s == 0) stg[s] <= d;
            else             stg[s] <= stg[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_pkg::*;
#(
   parameter int WIDTH   = 8,
   parameter bit SPECIAL = 1'b1,
   parameter int HI_BIT  = 7,
   parameter int LO_BIT  = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       addr,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] cfg_q,
   output logic [WIDTH-1:0] data_q,
   output logic [WIDTH-1:0] drv_q,
   output logic             halt_req,
   output logic             idle_req
);
   localparam logic [WIDTH-1:0] ONE       = WIDTH'(1);
   localparam logic [WIDTH-1:0] CTRL_MASK = SPECIAL ? ((ONE << HI_BIT) | (ONE << LO_BIT)) : '0;

   gpio_reg_e sel;
   assign sel = gpio_reg_e'(addr);

   logic wr_data, wr_cfg, wr_drv;
   assign wr_data = wr_en && (sel == REG_DATA);
   assign wr_cfg  = wr_en && (sel == REG_CFG);
   assign wr_drv  = wr_en && (sel == REG_DRV);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         data_q <= '0;
         drv_q  <= '1;
      end else begin
         if (wr_cfg)  cfg_q  <= wdata;
         if (wr_data) data_q <= wdata & ~CTRL_MASK;
         if (wr_drv)  drv_q  <= wdata;
      end
   end

   generate
      if (SPECIAL) begin : g_req
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               halt_req <= 1'b0;
               idle_req <= 1'b0;
            end else begin
               halt_req <= wr_data & wdata[HI_BIT];
               idle_req <= wr_data & wdata[LO_BIT];
            end
         end
      end else begin : g_noreq
         assign halt_req = 1'b0;
         assign idle_req = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
   import gpio_pkg::*;
(
   input  logic cfg_b,
   input  logic dat_b,
   input  logic force_hiz,
   input  logic wd_sel,
   input  logic wd_level,
   output logic oe,
   output logic out,
   output logic pu
);
   pin_drive_t m;
   always_comb begin
      m = decode_mode(cfg_b, dat_b);
      if (force_hiz) begin
         m = '0;
      end else if (wd_sel) begin
         m.oe  = ~wd_level;
         m.out = 1'b0;
         m.pu  = 1'b1;
      end
   end
   assign oe  = m.oe;
   assign out = m.out;
   assign pu  = m.pu;
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
   import gpio_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter bit SPECIAL     = 1'b1,
   parameter int HI_BIT      = 7,
   parameter int LO_BIT      = 6,
   parameter int WDOG_PIN    = 1,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       addr,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] rdata,
   input  logic [WIDTH-1:0] pad_in,
   output logic [WIDTH-1:0] pad_oe,
   output logic [WIDTH-1:0] pad_out,
   output logic [WIDTH-1:0] pad_pu,
   output logic [WIDTH-1:0] drv_port,
   input  logic             wdog_opt,
   input  logic             wdog_level,
   output logic             halt_req,
   output logic             idle_req,
   output logic             alt_sk_phase,
   output logic             clkdly_en
);
   generate
      if (SPECIAL && (HI_BIT >= WIDTH || LO_BIT >= WIDTH || HI_BIT == LO_BIT))
         begin : g_bad_ctrl
            $error("control bit positions invalid for WIDTH");
         end
      if (SPECIAL && (WDOG_PIN >= WIDTH || WDOG_PIN == HI_BIT || WDOG_PIN == LO_BIT))
         begin : g_bad_wdog
            $error("watchdog pin collides or is out of range");
         end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
   endgenerate

   localparam logic [WIDTH-1:0] ONE       = WIDTH'(1);
   localparam logic [WIDTH-1:0] CTRL_MASK = SPECIAL ? ((ONE << HI_BIT) | (ONE << LO_BIT)) : '0;
   localparam logic [WIDTH-1:0] WDOG_MASK = SPECIAL ? (ONE << WDOG_PIN) : '0;

   logic [WIDTH-1:0] cfg_q, data_q, drv_q, pin_q;

   gpio_regs #(
      .WIDTH(WIDTH), .SPECIAL(SPECIAL), .HI_BIT(HI_BIT), .LO_BIT(LO_BIT)
   ) regs_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .cfg_q(cfg_q), .data_q(data_q), .drv_q(drv_q),
      .halt_req(halt_req), .idle_req(idle_req)
   );

   gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_q)
   );

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_pin
         gpio_pin_cell cell_i (
            .cfg_b(cfg_q[i]), .dat_b(data_q[i]),
            .force_hiz(CTRL_MASK[i]),
            .wd_sel(WDOG_MASK[i] & wdog_opt),
            .wd_level(wdog_level),
            .oe(pad_oe[i]), .out(pad_out[i]), .pu(pad_pu[i])
         );
      end
      if (SPECIAL) begin : g_ctl
         assign alt_sk_phase = cfg_q[LO_BIT];
         assign clkdly_en    = cfg_q[HI_BIT];
      end else begin : g_noctl
         assign alt_sk_phase = 1'b0;
         assign clkdly_en    = 1'b0;
      end
   endgenerate

   assign drv_port = drv_q;

   always_comb begin
      case (gpio_reg_e'(addr))
         REG_DATA: rdata = data_q;
         REG_CFG:  rdata = cfg_q;
         REG_PIN:  rdata = pin_q;
         default:  rdata = drv_q;
      endcase
   end
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
   parameter int WIDTH    = 8,
   parameter bit SPECIAL  = 1'b1,
   parameter int HI_BIT   = 7,
   parameter int LO_BIT   = 6,
   parameter int WDOG_PIN = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [1:0]       addr,
   input logic [WIDTH-1:0] wdata,
   input logic [WIDTH-1:0] rdata,
   input logic [WIDTH-1:0] pad_oe,
   input logic [WIDTH-1:0] pad_out,
   input logic [WIDTH-1:0] pad_pu,
   input logic [WIDTH-1:0] drv_port,
   input logic             wdog_opt,
   input logic             wdog_level,
   input logic             halt_req,
   input logic             idle_req
);
   localparam logic [WIDTH-1:0] WMASK = SPECIAL ? (WIDTH'(1) << WDOG_PIN) : '0;

   // R1
   oe_pu_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe & pad_pu & ~WMASK) == '0));

   // R1
   out_needs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_out & ~pad_oe) == '0));

   // R5
   pin_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 2'd2) |=> $stable(drv_port));

   generate
      if (SPECIAL) begin : g_sp
         // R6
         halt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            halt_req |=> !halt_req || $past(wr_en && addr == 2'd0 && wdata[HI_BIT]));
         // R6
         halt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            halt_req |-> $past(wr_en && addr == 2'd0 && wdata[HI_BIT]));
         // R6
         idle_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            idle_req |-> $past(wr_en && addr == 2'd0 && wdata[LO_BIT]));
         // R7
         ctrl_pins_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !pad_oe[HI_BIT] && !pad_oe[LO_BIT] && !pad_pu[HI_BIT] && !pad_pu[LO_BIT]);
         // R8
         data_rd_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (addr == 2'd0) |-> (!rdata[HI_BIT] && !rdata[LO_BIT]));
         // R9
         wdog_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wdog_opt |-> (pad_pu[WDOG_PIN] && !pad_out[WDOG_PIN] && pad_oe[WDOG_PIN] == !wdog_level));
      end
   endgenerate
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(
   .WIDTH(WIDTH), .SPECIAL(SPECIAL), .HI_BIT(HI_BIT), .LO_BIT(LO_BIT), .WDOG_PIN(WDOG_PIN)
) chk_i (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
   .rdata(rdata), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
   .drv_port(drv_port), .wdog_opt(wdog_opt), .wdog_level(wdog_level),
   .halt_req(halt_req), .idle_req(idle_req)
);

// File: tb/gpio_port_ctrl_tb_top.sv
module gpio_port_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] pad_in = 8'h00;
   logic       wdog_opt = 1'b0;
   logic       wdog_level = 1'b1;
   logic [7:0] rdata, pad_oe, pad_out, pad_pu, drv_port;
   logic       halt_req, idle_req, alt_sk_phase, clkdly_en;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   // bench model
   logic [7:0] m_cfg = 8'h00, m_dat = 8'h00, m_drv = 8'hFF;
   logic       m_halt = 1'b0, m_idle = 1'b0;
   logic [7:0] s1, s2;

   always #4 clk = ~clk;

   gpio_port_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
      .pad_pu(pad_pu), .drv_port(drv_port), .wdog_opt(wdog_opt),
      .wdog_level(wdog_level), .halt_req(halt_req), .idle_req(idle_req),
      .alt_sk_phase(alt_sk_phase), .clkdly_en(clkdly_en)
   );

   // R5: two-edge pad sampling expectation
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1 <= 8'h00; s2 <= 8'h00;
      end else begin
         s1 <= pad_in; s2 <= s1;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [23:0] exp_pads(input logic [7:0] c, input logic [7:0] d,
                                            input logic wo, input logic wl);
      logic [7:0] oe, o, pu;
      for (int i = 0; i < 8; i++) begin
         if (i >= 6) begin
            oe[i] = 0; o[i] = 0; pu[i] = 0;
         end else if (i == 1 && wo) begin
            oe[i] = ~wl; o[i] = 0; pu[i] = 1;
         end else begin
            case ({c[i], d[i]})
               2'b00:   begin oe[i] = 0; o[i] = 0; pu[i] = 0; end
               2'b01:   begin oe[i] = 0; o[i] = 0; pu[i] = 1; end
               2'b10:   begin oe[i] = 1; o[i] = 0; pu[i] = 0; end
               default: begin oe[i] = 1; o[i] = 1; pu[i] = 0; end
            endcase
         end
      end
      return {oe, o, pu};
   endfunction

   function automatic logic [7:0] exp_rd(input logic [1:0] a);
      case (a)
         2'd0: return m_dat;
         2'd1: return m_cfg;
         2'd2: return s2;
         default: return m_drv;
      endcase
   endfunction

   // one bus cycle; inputs set at negedge, results checked at the next negedge
   task automatic cyc(input logic we, input logic [1:0] a, input logic [7:0] wd);
      wr_en = we; addr = a; wdata = wd;
      @(posedge clk);
      m_halt = we && a == 2'd0 && wd[7];
      m_idle = we && a == 2'd0 && wd[6];
      if (we) begin
         case (a)
            2'd0: m_dat = wd & 8'h3F;
            2'd1: m_cfg = wd;
            2'd3: m_drv = wd;
            default: ;
         endcase
      end
      @(negedge clk);
      wr_en = 1'b0;
      chk("R1 R9 pads", {8'h0, pad_oe, pad_out, pad_pu},
          {8'h0, exp_pads(m_cfg, m_dat, wdog_opt, wdog_level)});
      chk("R4 R5 R8 R10 rdata", {24'h0, rdata}, {24'h0, exp_rd(a)});
      chk("R6 halt", {31'h0, halt_req}, {31'h0, m_halt});
      chk("R6 idle", {31'h0, idle_req}, {31'h0, m_idle});
      chk("R7 ctrl", {30'h0, clkdly_en, alt_sk_phase}, {30'h0, m_cfg[7], m_cfg[6]});
      chk("R3 drv", {24'h0, drv_port}, {24'h0, m_drv});
   endtask

   initial begin : watchdog
      #(8 * 150000);
      if (!done) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'd20240611));
      // R2 R3: reset state
      repeat (3) @(negedge clk);
      chk("R2 oe", {24'h0, pad_oe}, 32'h0);
      chk("R2 pu", {24'h0, pad_pu}, 32'h0);
      chk("R3 reset drv", {24'h0, drv_port}, 32'hFF);
      addr = 2'd1;
      #1 chk("R2 cfg read", {24'h0, rdata}, 32'h0);
      addr = 2'd0;
      #1 chk("R2 data read", {24'h0, rdata}, 32'h0);
      rst_n = 1'b1;
      cyc(1'b0, 2'd0, 8'h00);

      // R1: each mode on each low pin
      cyc(1'b1, 2'd1, 8'h0C);
      cyc(1'b1, 2'd0, 8'h0A);
      cyc(1'b0, 2'd1, 8'h00);
      // R6 R8: control strobes, no storage
      cyc(1'b1, 2'd0, 8'h80);
      cyc(1'b0, 2'd0, 8'h00);
      cyc(1'b1, 2'd0, 8'h40);
      cyc(1'b1, 2'd0, 8'hC0);
      cyc(1'b1, 2'd0, 8'h3F);
      cyc(1'b0, 2'd0, 8'h00);
      // R7: control config bits, pins stay inputs
      cyc(1'b1, 2'd1, 8'hFF);
      cyc(1'b1, 2'd1, 8'h40);
      // R5: pin read independent of config, writes to pin ignored
      pad_in = 8'hA5;
      cyc(1'b0, 2'd2, 8'h00);
      cyc(1'b0, 2'd2, 8'h00);
      chk("R5 pin two edges", {24'h0, rdata}, 32'hA5);
      cyc(1'b1, 2'd2, 8'h5A);
      cyc(1'b0, 2'd1, 8'h00);
      // R3: drive port write
      cyc(1'b1, 2'd3, 8'h3C);
      // R9: watchdog overrides pin 1 with cfg/data = 11 and 00
      cyc(1'b1, 2'd1, 8'h02);
      cyc(1'b1, 2'd0, 8'h02);
      wdog_opt = 1'b1; wdog_level = 1'b0;
      cyc(1'b0, 2'd0, 8'h00);
      wdog_level = 1'b1;
      cyc(1'b0, 2'd0, 8'h00);
      cyc(1'b1, 2'd1, 8'h00);
      cyc(1'b1, 2'd0, 8'h00);
      wdog_opt = 1'b0;
      cyc(1'b0, 2'd1, 8'h00);

      // random mix
      for (int k = 0; k < 600; k++) begin
         if (k % 150 == 0) wdog_opt = ~wdog_opt;
         wdog_level = 1'($urandom);
         pad_in = 8'($urandom);
         cyc(1'($urandom), 2'($urandom), 8'($urandom));
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule